// File: doc/BRIEF.md
# Integer Arithmetic and Compare Unit

A purely combinational integer unit for a small RISC execution stage. It takes two operands, a shift distance and a 6-bit function code straight from a register-to-register instruction word, and it produces a result word and a flag that is high when the result is all zeros. The function code is decoded inside the block, so the decoder upstream does not need its own operation table for register-format arithmetic.

The operations are wrapping addition and subtraction, bitwise AND, OR and NOR, logical shifts in both directions, and separate signed and unsigned less-than tests that return 0 or 1. Bitwise inversion has no code of its own: it comes from NOR against a zero operand. Shifts act on the second operand, which is the field that names the target register in the instruction format, by the shift-distance input. A function code that the block does not recognise gives a result of zero.

The house state-machine layout does not apply, because the block holds no state. The decoder instead maps each function code onto an enumerated operation with a unique case. The operations are: none (undefined code), add, subtract, and, or, nor, signed less-than, unsigned less-than, shift left and shift right.

Top module: `alu_core`

## Requirements
- R1: Function code 32 gives `opnd_a + opnd_b` modulo 2^WIDTH. For example, 0xFFFFFFFF + 1 gives 0.
- R2: Function code 34 gives `opnd_a - opnd_b` modulo 2^WIDTH, with no overflow indication.
- R3: Function code 36 gives the bitwise AND of the operands. Function code 37 gives their bitwise OR.
- R4: Function code 39 gives the inversion of (`opnd_a` OR `opnd_b`). With `opnd_b` = 0 this is the bitwise NOT of `opnd_a`.
- R5: Function code 42 gives 1 when `opnd_a` is below `opnd_b` as two's-complement numbers, and 0 otherwise. All-ones compared with 1 gives 1.
- R6: Function code 43 gives 1 when `opnd_a` is below `opnd_b` as unsigned numbers, and 0 otherwise. All-ones compared with 1 gives 0.
- R7: Function code 0 gives `opnd_b` shifted left by `shamt` places, with zeros shifted in at the bottom.
- R8: Function code 2 gives `opnd_b` shifted right by `shamt` places, with zeros shifted in at the top.
- R9: Every function code other than 0, 2, 32, 34, 36, 37, 39, 42 and 43 gives a result of 0.
- R10: `zero` is 1 exactly when `result` is 0.
- R11: `shamt` has no effect on the result of any function code other than 0 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH (32) | First source operand |
| opnd_b | input | WIDTH (32) | Second source operand; also the value that is shifted |
| shamt | input | $clog2(WIDTH) (5) | Shift distance |
| func | input | 6 | Function code from the instruction word |
| result | output | WIDTH (32) | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Some properties are checked continuously by the embedded assertions. The adder's output, taken back through the opposite operation, must return `opnd_a`. The two less-than outputs must follow the sign bits whenever those bits differ, and both must be low for equal operands. A zero shift distance must pass the value through, and any nonzero distance must clear the bit vacated at each end. A NOR result must share no set bit with either operand. The function-code mapping, the handling of undefined codes, the independence of non-shift results from `shamt`, and the exact bits of each result can only be shown by the bench. It sweeps all 64 codes against a set of corner-case operands, checks every shift distance, and computes each expected word arithmetically.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_NOR,
        OP_SLT,
        OP_SLTU,
        OP_SLL,
        OP_SRL
    } alu_op_e;

    localparam int FUNC_W = 6;

    localparam logic [FUNC_W-1:0] FN_SLL  = 6'd0;
    localparam logic [FUNC_W-1:0] FN_SRL  = 6'd2;
    localparam logic [FUNC_W-1:0] FN_ADD  = 6'd32;
    localparam logic [FUNC_W-1:0] FN_SUB  = 6'd34;
    localparam logic [FUNC_W-1:0] FN_AND  = 6'd36;
    localparam logic [FUNC_W-1:0] FN_OR   = 6'd37;
    localparam logic [FUNC_W-1:0] FN_NOR  = 6'd39;
    localparam logic [FUNC_W-1:0] FN_SLT  = 6'd42;
    localparam logic [FUNC_W-1:0] FN_SLTU = 6'd43;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output alu_op_e           op
);

    always_comb begin
        unique case (func)
            FN_ADD:  op = OP_ADD;
            FN_SUB:  op = OP_SUB;
            FN_AND:  op = OP_AND;
            FN_OR:   op = OP_OR;
            FN_NOR:  op = OP_NOR;
            FN_SLT:  op = OP_SLT;
            FN_SLTU: op = OP_SLTU;
            FN_SLL:  op = OP_SLL;
            FN_SRL:  op = OP_SRL;
            default: op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum
);

    logic [WIDTH-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
    end

    // Undoing the operation must give back the first operand (wrapping arithmetic).
    always_comb begin
        if (!sub) assert_add_wraps_R1: assert ((sum - b) == a);
        if (sub)  assert_sub_wraps_R2: assert ((sum + b) == a);
    end

endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             lt_s,
    output logic             lt_u
);

    always_comb begin
        lt_u = (a < b);
        lt_s = ($signed(a) < $signed(b));
    end

    always_comb begin
        // Differing sign bits: the negative one is smaller when signed,
        // the one with the top bit set is larger when unsigned.
        if (a[WIDTH-1] != b[WIDTH-1]) begin
            assert_signed_sign_R5:   assert (lt_s == a[WIDTH-1]);
            assert_unsigned_sign_R6: assert (lt_u == b[WIDTH-1]);
        end
        if (a == b) begin
            assert_equal_not_less_R5: assert (!lt_s && !lt_u);
        end
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val,
    input  logic [SHW-1:0]   amt,
    output logic [WIDTH-1:0] shl,
    output logic [WIDTH-1:0] shr
);

    always_comb begin
        shl = val << amt;
        shr = val >> amt;
    end

    always_comb begin
        if (amt == '0) begin
            assert_shift_zero_pass_R7: assert (shl == val && shr == val);
        end else begin
            assert_shl_fill_R7: assert (shl[0] == 1'b0);
            assert_shr_fill_R8: assert (shr[WIDTH-1] == 1'b0);
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic [SHW-1:0]    shamt,
    input  logic [FUNC_W-1:0] func,
    output logic [WIDTH-1:0]  result,
    output logic              zero
);

    alu_op_e          op;
    logic [WIDTH-1:0] arith;
    logic             lt_s;
    logic             lt_u;
    logic [WIDTH-1:0] shl;
    logic [WIDTH-1:0] shr;
    logic             do_sub;

    assign do_sub = (op == OP_SUB);

    alu_decode u_decode (
        .func (func),
        .op   (op)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a   (opnd_a),
        .b   (opnd_b),
        .sub (do_sub),
        .sum (arith)
    );

    alu_compare #(.WIDTH(WIDTH)) u_compare (
        .a    (opnd_a),
        .b    (opnd_b),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    alu_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shifter (
        .val (opnd_b),
        .amt (shamt),
        .shl (shl),
        .shr (shr)
    );

    always_comb begin
        unique case (op)
            OP_ADD,
            OP_SUB:  result = arith;
            OP_AND:  result = opnd_a & opnd_b;
            OP_OR:   result = opnd_a | opnd_b;
            OP_NOR:  result = ~(opnd_a | opnd_b);
            OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt_s};
            OP_SLTU: result = {{(WIDTH-1){1'b0}}, lt_u};
            OP_SLL:  result = shl;
            OP_SRL:  result = shr;
            default: result = '0;
        endcase
        zero = (result == '0);
    end

    always_comb begin
        if (op == OP_NOR) begin
            assert_nor_disjoint_R4: assert ((result & (opnd_a | opnd_b)) == '0);
        end
        if (op == OP_SLT || op == OP_SLTU) begin
            assert_compare_one_bit_R5: assert (result[WIDTH-1:1] == '0);
        end
        if (op == OP_NONE) begin
            assert_undefined_zero_R9: assert (zero);
        end
    end

endmodule

// File: tb/tb_alu_core.sv
`timescale 1ns/1ps
module tb_alu_core;

    localparam int W   = 32;
    localparam int SHW = 5;
    localparam int NPAT = 12;

    logic          clk = 1'b0;
    logic [W-1:0]  opnd_a = '0;
    logic [W-1:0]  opnd_b = '0;
    logic [SHW-1:0] shamt = '0;
    logic [5:0]    func = '0;
    logic [W-1:0]  result;
    logic          zero;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    alu_core #(.WIDTH(W), .SHW(SHW)) dut (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .shamt  (shamt),
        .func   (func),
        .result (result),
        .zero   (zero)
    );

    function automatic logic [W-1:0] pat(input int k);
        case (k)
            0:  pat = 32'h0000_0000;
            1:  pat = 32'h0000_0001;
            2:  pat = 32'h0000_0002;
            3:  pat = 32'hFFFF_FFFF;
            4:  pat = 32'hFFFF_FFFE;
            5:  pat = 32'h8000_0000;
            6:  pat = 32'h7FFF_FFFF;
            7:  pat = 32'h0000_0DC0;
            8:  pat = 32'h0000_3C00;
            9:  pat = 32'h1234_5678;
            10: pat = 32'hAAAA_AAAA;
            default: pat = 32'h0232_4020;
        endcase
    endfunction

    function automatic logic [W-1:0] model(input int f, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input int s);
        logic [63:0] wide;
        case (f)
            32: begin wide = {32'd0, a} + {32'd0, b}; model = wide[31:0]; end
            34: begin wide = {32'd1, a} - {32'd0, b}; model = wide[31:0]; end
            36: model = a & b;
            37: model = a | b;
            39: model = ~(a | b);
            42: model = ((a[31] & ~b[31]) | ((a[31] == b[31]) & (a < b))) ? 32'd1 : 32'd0;
            43: model = (a < b) ? 32'd1 : 32'd0;
            0:  begin wide = {32'd0, b} * (64'd1 << s); model = wide[31:0]; end
            2:  begin wide = {32'd0, b} / (64'd1 << s); model = wide[31:0]; end
            default: model = 32'd0;
        endcase
    endfunction

    function automatic string tag(input int f, input int s);
        case (f)
            32: tag = "R1";
            34: tag = "R2";
            36, 37: tag = "R3";
            39: tag = "R4";
            42: tag = "R5";
            43: tag = "R6";
            0:  tag = "R7";
            2:  tag = "R8";
            default: tag = "R9";
        endcase
        if (f != 0 && f != 2 && s != 0) tag = {tag, "/R11"};
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic apply(input int f, input logic [W-1:0] a, input logic [W-1:0] b, input int s);
        logic [W-1:0] exp;
        @(posedge clk);
        func   = 6'(f);
        opnd_a = a;
        opnd_b = b;
        shamt  = SHW'(s);
        @(negedge clk);
        exp = model(f, a, b, s);
        vectors++;
        if (result !== exp) begin
            fails++;
            $display("FAIL %s func=%0d a=%h b=%h sh=%0d: result %h expected %h",
                     tag(f, s), f, a, b, s, result, exp);
        end
        if (zero !== (exp == '0)) begin
            fails++;
            $display("FAIL R10 func=%0d a=%h b=%h: zero %b expected %b",
                     f, a, b, zero, (exp == '0));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            finish_run();
        end
    end

    initial begin
        // Initial state: all inputs zero selects a shift of zero, result 0, zero flag high (R7, R10).
        @(negedge clk);
        vectors++;
        if (result !== '0 || zero !== 1'b1) begin
            fails++;
            $display("FAIL R10 initial: result %h zero %b expected 0 and 1", result, zero);
        end

        // Named corner cases.
        apply(32, 32'h0000_0011, 32'h0000_0012, 0);   // R1 simple add
        apply(32, 32'hFFFF_FFFF, 32'h0000_0001, 0);   // R1 wraps to zero, R10
        apply(34, 32'h0000_0000, 32'h0000_0001, 0);   // R2 wraps to all ones
        apply(39, 32'h0000_3C00, 32'h0000_0000, 0);   // R4 NOT via zero operand
        apply(42, 32'hFFFF_FFFF, 32'h0000_0001, 0);   // R5 -1 < 1 gives 1
        apply(43, 32'hFFFF_FFFF, 32'h0000_0001, 0);   // R6 big unsigned gives 0
        apply(0,  32'h0000_0000, 32'h8000_0001, 31);  // R7 bit 0 to top
        apply(2,  32'h0000_0000, 32'h8000_0001, 31);  // R8 top bit to bit 0
        apply(17, 32'h1234_5678, 32'h1111_1111, 0);   // R9 undefined code

        // Sweep of every function code over operand pairs and shift distances.
        for (int f = 0; f < 64; f++) begin
            for (int i = 0; i < NPAT; i++) begin
                for (int j = 0; j < NPAT; j++) begin
                    if (f == 0 || f == 2) begin
                        for (int s = 0; s < 32; s++) apply(f, pat(i), pat(j), s);
                    end else begin
                        for (int k = 0; k < 3; k++)
                            apply(f, pat(i), pat(j), (k == 0) ? 0 : ((k == 1) ? 13 : 31));
                    end
                end
            end
        end

        done = 1'b1;
        finish_run();
    end

endmodule